// File: doc/BRIEF.md
# All-Frame-Mode Counter Controller

This block holds the all-frame-mode state of a paging-protocol receiver. It keeps one shared all-frame counter and sixteen enable counters, one for each temporary address. All of them are seven-bit saturating counters. The receiver raises the shared counter each time it reports a received vector of the alphanumeric, hex/binary or secure kind. A sixteen-bit strobe vector raises the enable counters.

The host lowers counters by writing 32-bit control words that arrive already framed with a valid strobe. Only words whose top byte carries the all-frame-mode identifier act on this block. One such word can lower the shared counter and any set of enable counters in the same cycle. The same word also reloads a force bit that holds the mode on whatever the counters hold.

Outputs are a per-address enable vector and the all-frame-mode flag. Both come straight from registers, so an input sampled at a clock edge shows on the outputs right after that edge.

Top module: `afm_ctrl`

## Requirements
- R1: After reset all counters and the force bit are zero, so `afm_flag` and every bit of `ta_en` read 0.
- R2: With `dec_en` high, a cycle with `vec_evt` high raises the shared counter by one.
- R3: Every counter stops at 127 on increment and does not wrap. After 130 increments, exactly 127 decrements are needed to bring it back to zero.
- R4: A decrement applied to a counter at zero leaves it at zero.
- R5: A cycle with `dec_en` low clears every counter to zero, and increments and decrements in that cycle are dropped.
- R6: A word with `pkt_valid` high is accepted only when bits 31:24 equal 3. Words with any other identifier change no counter and do not change the force bit.
- R7: In an accepted word, bit 23 set lowers the shared counter by one. Bit 23 clear leaves that counter alone.
- R8: Every accepted word loads bit 22 into the force bit, and the force bit set drives `afm_flag` high whatever the counters hold.
- R9: In an accepted word, bit k of 15:0 set lowers enable counter k by one. A clear bit leaves that counter alone.
- R10: `ta_en[k]` is high exactly when enable counter k is nonzero. `ta_inc[k]` raises that counter when `dec_en` is high.
- R11: `afm_flag` is high when the force bit is set, or the shared counter is nonzero, or any enable counter is nonzero.
- R12: When an increment and a decrement reach the same counter in one cycle, they cancel and the counter keeps its value.
- R13: Bits 21:16 of an accepted word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | Receiver enabled. Low clears all counters |
| vec_evt | input | 1 | Qualifying vector received; raises the shared counter |
| ta_inc | input | 16 | Per-address increment strobes |
| pkt_valid | input | 1 | Host control word valid |
| pkt_data | input | 32 | Host control word |
| afm_flag | output | 1 | All-frame mode active |
| ta_en | output | 16 | Temporary address k enabled |

## Verification
The bench drives each counter past its ceiling and then counts decrements back down. A design that wrapped, or that saturated one step early or late, would drop the flag after the wrong number of words. It also hits a counter at zero and checks that a following single increment is undone by a single decrement; a design that wrapped below zero would then leave the flag stuck high. The bench also collides increments with decrements, sends words with foreign identifiers and reserved bits set, and pulses the enable low. A design that let these through would show a flag that differs from the bench model's.

// File: rtl/afm_pkg.sv
package afm_pkg;
   localparam int PKT_W     = 32;
   localparam int ID_LSB    = 24;
   localparam int DAF_BIT   = 23;
   localparam int FAF_BIT   = 22;
   localparam int RSV_MSB   = 21;
   localparam int RSV_LSB   = 16;
   localparam int DTA_W     = 16;

   typedef struct packed {
      logic             hit;
      logic             dec_all;
      logic             force_val;
      logic [DTA_W-1:0] dta;
   } afm_cmd_t;
endpackage

// File: rtl/afm_sat_cnt.sv
module afm_sat_cnt #(
   parameter int W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic nz
);
   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (clr)                        q <= '0;
      else if (inc && !dec && q != TOP)    q <= q + 1'b1;
      else if (dec && !inc && q != '0)     q <= q - 1'b1;
   end

   assign nz = |q;
endmodule

// File: rtl/afm_pkt_dec.sv
module afm_pkt_dec
   import afm_pkg::*;
#(
   parameter logic [7:0] PKT_ID = 8'd3
) (
   input  logic             pkt_valid,
   input  logic [PKT_W-1:0] pkt_data,
   output afm_cmd_t         cmd
);
   logic hit;
   logic unused_rsv;

   assign hit            = pkt_valid && (pkt_data[PKT_W-1:ID_LSB] == PKT_ID);
   assign cmd.hit        = hit;
   assign cmd.dec_all    = hit & pkt_data[DAF_BIT];
   assign cmd.force_val  = pkt_data[FAF_BIT];
   assign cmd.dta        = hit ? pkt_data[DTA_W-1:0] : '0;
   assign unused_rsv     = ^pkt_data[RSV_MSB:RSV_LSB];
endmodule

// File: rtl/afm_ctrl.sv
module afm_ctrl
   import afm_pkg::*;
#(
   parameter int         CNT_W  = 7,
   parameter int         N_TA   = 16,
   parameter logic [7:0] PKT_ID = 8'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_en,
   input  logic              vec_evt,
   input  logic [N_TA-1:0]   ta_inc,
   input  logic              pkt_valid,
   input  logic [PKT_W-1:0]  pkt_data,
   output logic              afm_flag,
   output logic [N_TA-1:0]   ta_en
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
      $error("afm_ctrl: CNT_W out of range");
   end
   if (N_TA < 1 || N_TA > DTA_W) begin : g_bad_n
      $error("afm_ctrl: N_TA out of range");
   end

   afm_cmd_t cmd;
   logic     all_nz;
   logic     force_q;

   afm_pkt_dec #(.PKT_ID(PKT_ID)) i_dec (
      .pkt_valid (pkt_valid),
      .pkt_data  (pkt_data),
      .cmd       (cmd)
   );

   afm_sat_cnt #(.W(CNT_W)) i_all (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!dec_en),
      .inc   (vec_evt),
      .dec   (cmd.dec_all),
      .nz    (all_nz)
   );

   for (genvar k = 0; k < N_TA; k++) begin : g_ta
      afm_sat_cnt #(.W(CNT_W)) i_ta (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!dec_en),
         .inc   (ta_inc[k]),
         .dec   (cmd.dta[k]),
         .nz    (ta_en[k])
      );
   end

   if (N_TA < DTA_W) begin : g_spare
      logic unused_dta;
      assign unused_dta = ^cmd.dta[DTA_W-1:N_TA];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       force_q <= 1'b0;
      else if (cmd.hit) force_q <= cmd.force_val;
   end

   assign afm_flag = force_q | all_nz | (|ta_en);
endmodule

// File: rtl/afm_ctrl_chk.sv
module afm_ctrl_chk #(
   parameter int         N_TA   = 16,
   parameter logic [7:0] PKT_ID = 8'd3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dec_en,
   input logic            vec_evt,
   input logic [N_TA-1:0] ta_inc,
   input logic            pkt_valid,
   input logic [31:0]     pkt_data,
   input logic            afm_flag,
   input logic [N_TA-1:0] ta_en
);
   logic acc;
   assign acc = pkt_valid && (pkt_data[31:24] == PKT_ID);

   // R5
   clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_en |=> (ta_en == '0));

   // R8
   force_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && pkt_data[22]) |=> afm_flag);

   // R6
   foreign_id_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !vec_evt && ta_inc == '0 && pkt_valid && !acc)
      |=> ($stable(ta_en) && $stable(afm_flag)));

   // R10
   ta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && ta_inc == '0 && !(acc && pkt_data[N_TA-1:0] != '0))
      |=> $stable(ta_en));

   // R11
   ta_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ta_en != '0) |-> afm_flag);
endmodule

bind afm_ctrl afm_ctrl_chk #(.N_TA(N_TA), .PKT_ID(PKT_ID)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dec_en    (dec_en),
   .vec_evt   (vec_evt),
   .ta_inc    (ta_inc),
   .pkt_valid (pkt_valid),
   .pkt_data  (pkt_data),
   .afm_flag  (afm_flag),
   .ta_en     (ta_en)
);

// File: tb/test_afm_ctrl.sv
`timescale 1ns/1ps
module test_afm_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_en = 1'b0;
   logic        vec_evt = 1'b0;
   logic [15:0] ta_inc = '0;
   logic        pkt_valid = 1'b0;
   logic [31:0] pkt_data = '0;
   logic        afm_flag;
   logic [15:0] ta_en;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   int    m_all;
   int    m_ta [16];
   bit    m_force;

   always #10 clk = ~clk;

   afm_ctrl i_afm_ctrl (
      .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .vec_evt(vec_evt),
      .ta_inc(ta_inc), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .afm_flag(afm_flag), .ta_en(ta_en)
   );

   function automatic int sat_step(int v, bit up, bit dn);
      if (up && !dn && v < 127) return v + 1;
      if (dn && !up && v > 0)   return v - 1;
      return v;
   endfunction

   function automatic logic [15:0] exp_en();
      logic [15:0] e;
      for (int k = 0; k < 16; k++) e[k] = (m_ta[k] != 0);
      return e;
   endfunction

   function automatic logic exp_flag();
      return m_force || (m_all != 0) || (exp_en() != 0);
   endfunction

   task automatic compare();
      checks++;
      if (ta_en !== exp_en()) begin
         errors++;
         $display("FAIL %s ta_en actual %h expected %h", cur_req, ta_en, exp_en());
      end
      checks++;
      if (afm_flag !== exp_flag()) begin
         errors++;
         $display("FAIL %s afm_flag actual %b expected %b", cur_req, afm_flag, exp_flag());
      end
   endtask

   task automatic step(input logic ev, input logic [15:0] inc, input logic pv,
                       input logic [31:0] pd, input logic en);
      bit acc;
      @(negedge clk);
      vec_evt = ev; ta_inc = inc; pkt_valid = pv; pkt_data = pd; dec_en = en;
      @(posedge clk);
      acc = pv && (pd[31:24] == 8'd3);
      if (!en) begin
         m_all = 0;
         for (int k = 0; k < 16; k++) m_ta[k] = 0;
      end else begin
         m_all = sat_step(m_all, ev, acc && pd[23]);
         for (int k = 0; k < 16; k++) m_ta[k] = sat_step(m_ta[k], inc[k], acc && pd[k]);
      end
      if (acc) m_force = pd[22];
      #2;
      compare();
   endtask

   task automatic idle(); step(1'b0, '0, 1'b0, '0, 1'b1); endtask
   task automatic vec(); step(1'b1, '0, 1'b0, '0, 1'b1); endtask
   task automatic pkt(input logic [31:0] pd); step(1'b0, '0, 1'b1, pd, 1'b1); endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      m_all = 0; m_force = 0;
      for (int k = 0; k < 16; k++) m_ta[k] = 0;
      #45 rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1"; compare();

      cur_req = "R2"; vec();
      cur_req = "R7"; pkt(32'h0380_0000);
      cur_req = "R4"; pkt(32'h0380_0000); pkt(32'h0380_0000); vec(); pkt(32'h0380_0000);

      cur_req = "R3";
      for (int i = 0; i < 130; i++) vec();
      for (int i = 0; i < 127; i++) pkt(32'h0380_0000);
      idle();

      cur_req = "R10"; for (int i = 0; i < 3; i++) step(1'b0, 16'h0020, 1'b0, '0, 1'b1);
      cur_req = "R11"; idle();
      cur_req = "R9"; for (int i = 0; i < 3; i++) pkt(32'h0300_0020);

      cur_req = "R3";
      for (int i = 0; i < 130; i++) step(1'b0, 16'h0200, 1'b0, '0, 1'b1);
      for (int i = 0; i < 127; i++) pkt(32'h0300_0200);

      cur_req = "R6";
      vec(); step(1'b0, 16'h0001, 1'b0, '0, 1'b1);
      pkt(32'h0480_0001); pkt(32'h8340_0001); pkt(32'h0040_0001);
      pkt(32'h0380_0001);

      cur_req = "R8";
      pkt(32'h0340_0000); idle(); pkt(32'h0300_0000);

      cur_req = "R12";
      step(1'b0, 16'h0008, 1'b0, '0, 1'b1);
      step(1'b0, 16'h0008, 1'b1, 32'h0300_0008, 1'b1);
      pkt(32'h0300_0008);
      vec(); step(1'b1, '0, 1'b1, 32'h0380_0000, 1'b1); pkt(32'h0380_0000);

      cur_req = "R13";
      vec(); pkt(32'h03BF_0000); pkt(32'h033F_0004);

      cur_req = "R5";
      vec(); step(1'b0, 16'hF00F, 1'b0, '0, 1'b1);
      step(1'b1, 16'h00F0, 1'b1, 32'h0380_0001, 1'b0);
      idle();

      cur_req = "R11";
      for (int i = 0; i < 3000; i++) begin
         logic        ev  = ($urandom % 4) == 0;
         logic [15:0] inc = (($urandom % 3) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
         logic        pv  = ($urandom % 3) == 0;
         logic [31:0] pd  = $urandom;
         logic        en  = ($urandom % 300) != 0;
         if (($urandom % 4) != 0) pd[31:24] = 8'd3;
         pd[15:0] = pd[15:0] & 16'($urandom) & 16'($urandom);
         if (($urandom % 4) != 0) pd[22] = 1'b0;
         step(ev, inc, pv, pd, en);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule